// File: doc/BRIEF.md
# Flag-Producing Integer ALU

This block is the combinational heart of a processor's integer data path. It takes two operands, the second one already passed through the operand shifter, and one of sixteen operations chosen by a 4-bit code. It returns the operation's result together with the next negative, zero, carry and overflow flags. It also produces two enables that tell the surrounding pipeline whether to write the result and whether to commit the flags.

Arithmetic operations all share one adder. Each operation is mapped onto that adder by choosing which operand goes on which input, whether an operand is inverted, and what the carry-in is. Because of this, the carry flag of a subtraction means "no borrow". Logical operations do not touch the adder. For them, the carry flag comes from the shifter's carry-out and the overflow flag keeps its current value. The four compare/test operations compute a value only to set flags: they always commit flags and never write a result. Every other operation commits flags only when the caller asks for it.

Top module: `dp_alu`

## Requirements
- R1: The logical codes give these results: 0000 gives A AND B, 0001 gives A XOR B, 1100 gives A OR B, 1101 gives B, 1110 gives A AND NOT B, 1111 gives NOT B. Test 1000 computes A AND B and test-equivalence 1001 computes A XOR B.
- R2: Add (0100) and compare-negative (1011) compute A + B. C is set when the unsigned 33-bit sum exceeds the largest 32-bit value, and V is set on signed two's-complement overflow.
- R3: Subtract (0010) and compare (1010) compute A − B. C is set when B is unsigned less than or equal to A (no borrow), and V is set on signed overflow.
- R4: Reverse subtract (0011) computes B − A. C is set when A is unsigned less than or equal to B, and V is set on signed overflow.
- R5: The carry-chained codes use the incoming C flag: 0101 computes A + B + C, 0110 computes A + NOT B + C, and 0111 computes B + NOT A + C. C is the carry out of that 33-bit sum. V is set when the two adder inputs share a sign bit and the result's sign differs from them.
- R6: N equals bit 31 of the result, and Z is set exactly when the result is zero, for every code.
- R7: For the logical codes (0000, 0001, 1000, 1001, 1100–1111), the next C equals the shifter carry-out and the next V equals the incoming V flag.
- R8: The result-write enable is low for codes 1000–1011 and high for all other codes.
- R9: The flag-update enable is high for codes 1000–1011 whatever the set-flags request. For all other codes it equals the set-flags request.
- R10: The incoming C flag has no effect on any output for add, subtract, reverse subtract or any logical code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand (A) |
| opb_i | input | 32 | Second operand (B), already shifted |
| c_flag_i | input | 1 | Current carry flag |
| v_flag_i | input | 1 | Current overflow flag |
| shift_c_i | input | 1 | Carry-out of the operand shifter |
| set_flags_i | input | 1 | Request to commit flags |
| result_o | output | 32 | Operation result |
| result_we_o | output | 1 | Result-write enable |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| v_o | output | 1 | Next overflow flag |
| flags_we_o | output | 1 | Flag-update enable |

## Verification
Every code is driven with a matrix of corner operands: 0, 1, the largest positive value, the most negative value and all-ones. This matrix separates the no-borrow carry sense from a borrow sense, and it puts both operand orders on each side of the signed overflow boundaries. Each vector is applied with the incoming carry both clear and set, which separates the carry-chained codes from their plain forms and shows that the plain codes ignore that flag. Set-flags, shifter carry and incoming overflow are varied independently, so that the enables and the flag passthrough for logical codes cannot be confused with one another. Several thousand random vectors then cover the ordinary mid-range values.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND   = 4'h0,
      OP_XOR   = 4'h1,
      OP_SUB   = 4'h2,
      OP_RSUB  = 4'h3,
      OP_ADD   = 4'h4,
      OP_ADDC  = 4'h5,
      OP_SUBC  = 4'h6,
      OP_RSUBC = 4'h7,
      OP_TAND  = 4'h8,
      OP_TXOR  = 4'h9,
      OP_CSUB  = 4'hA,
      OP_CADD  = 4'hB,
      OP_OR    = 4'hC,
      OP_PASS  = 4'hD,
      OP_CLR   = 4'hE,
      OP_INV   = 4'hF
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } alu_flags_t;

   // compare/test group: flags only, never a result write
   function automatic logic op_is_compare(input alu_op_e op);
      return (op == OP_TAND) || (op == OP_TXOR) || (op == OP_CSUB) || (op == OP_CADD);
   endfunction

   function automatic logic op_is_arith(input alu_op_e op);
      case (op)
         OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC, OP_RSUBC, OP_CSUB, OP_CADD: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             ci_i,
   output logic [WIDTH-1:0] s_o,
   output logic             co_o
);

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = ci_i;
         for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            assign s_o[g]    = x_i[g] ^ y_i[g] ^ cy[g];
            assign cy[g+1]   = (x_i[g] & y_i[g]) | (cy[g] & (x_i[g] ^ y_i[g]));
         end
         assign co_o = cy[WIDTH];
      end else begin : g_infer
         logic [WIDTH:0] sum_w;
         assign sum_w = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, ci_i};
         assign s_o   = sum_w[WIDTH-1:0];
         assign co_o  = sum_w[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
   import dp_alu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             ovf_o
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] x_sel, y_sel;
   logic             ci_sel;

   // map each arithmetic code onto one adder: operand order, inversion, carry-in
   always_comb begin
      x_sel  = a_i;
      y_sel  = b_i;
      ci_sel = 1'b0;
      case (op_i)
         OP_SUB, OP_CSUB: begin x_sel = a_i; y_sel = ~b_i; ci_sel = 1'b1;  end
         OP_RSUB:         begin x_sel = b_i; y_sel = ~a_i; ci_sel = 1'b1;  end
         OP_ADD, OP_CADD: begin x_sel = a_i; y_sel = b_i;  ci_sel = 1'b0;  end
         OP_ADDC:         begin x_sel = a_i; y_sel = b_i;  ci_sel = cin_i; end
         OP_SUBC:         begin x_sel = a_i; y_sel = ~b_i; ci_sel = cin_i; end
         OP_RSUBC:        begin x_sel = b_i; y_sel = ~a_i; ci_sel = cin_i; end
         default:         begin x_sel = a_i; y_sel = b_i;  ci_sel = 1'b0;  end
      endcase
   end

   dp_alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_adder (
      .x_i  (x_sel),
      .y_i  (y_sel),
      .ci_i (ci_sel),
      .s_o  (sum_o),
      .co_o (cout_o)
   );

   assign ovf_o = (x_sel[MSB] == y_sel[MSB]) && (sum_o[MSB] != x_sel[MSB]);

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
   import dp_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] res_o
);

   always_comb begin
      case (op_i)
         OP_AND, OP_TAND: res_o = a_i & b_i;
         OP_XOR, OP_TXOR: res_o = a_i ^ b_i;
         OP_OR:           res_o = a_i | b_i;
         OP_PASS:         res_o = b_i;
         OP_CLR:          res_o = a_i & ~b_i;
         OP_INV:          res_o = ~b_i;
         default:         res_o = '0;
      endcase
   end

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
   import dp_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] res_i,
   input  logic             arith_i,
   input  logic             add_c_i,
   input  logic             add_v_i,
   input  logic             shift_c_i,
   input  logic             v_keep_i,
   output alu_flags_t       flags_o
);

   localparam int MSB = WIDTH - 1;

   always_comb begin
      flags_o.n = res_i[MSB];
      flags_o.z = ~|res_i;
      flags_o.c = arith_i ? add_c_i : shift_c_i;
      flags_o.v = arith_i ? add_v_i : v_keep_i;
   end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_alu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [3:0]       op_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic             c_flag_i,
   input  logic             v_flag_i,
   input  logic             shift_c_i,
   input  logic             set_flags_i,
   output logic [WIDTH-1:0] result_o,
   output logic             result_we_o,
   output logic             n_o,
   output logic             z_o,
   output logic             c_o,
   output logic             v_o,
   output logic             flags_we_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dp_alu: WIDTH must be at least 2");
      end
   endgenerate

   alu_op_e          op;
   logic             is_arith, is_cmp;
   logic [WIDTH-1:0] sum_w, log_w;
   logic             add_c, add_v;
   alu_flags_t       nxt;

   assign op       = alu_op_e'(op_i);
   assign is_arith = op_is_arith(op);
   assign is_cmp   = op_is_compare(op);

   dp_alu_arith #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_arith (
      .op_i   (op),
      .a_i    (opa_i),
      .b_i    (opb_i),
      .cin_i  (c_flag_i),
      .sum_o  (sum_w),
      .cout_o (add_c),
      .ovf_o  (add_v)
   );

   dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .op_i  (op),
      .a_i   (opa_i),
      .b_i   (opb_i),
      .res_o (log_w)
   );

   assign result_o = is_arith ? sum_w : log_w;

   dp_alu_flags #(.WIDTH(WIDTH)) u_flags (
      .res_i     (result_o),
      .arith_i   (is_arith),
      .add_c_i   (add_c),
      .add_v_i   (add_v),
      .shift_c_i (shift_c_i),
      .v_keep_i  (v_flag_i),
      .flags_o   (nxt)
   );

   assign n_o         = nxt.n;
   assign z_o         = nxt.z;
   assign c_o         = nxt.c;
   assign v_o         = nxt.v;
   assign result_we_o = ~is_cmp;
   assign flags_we_o  = is_cmp | set_flags_i;

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic [3:0]       op_i,
   input logic [WIDTH-1:0] opa_i,
   input logic [WIDTH-1:0] opb_i,
   input logic             c_flag_i,
   input logic             v_flag_i,
   input logic             shift_c_i,
   input logic             set_flags_i,
   input logic [WIDTH-1:0] result_o,
   input logic             result_we_o,
   input logic             n_o,
   input logic             z_o,
   input logic             c_o,
   input logic             v_o,
   input logic             flags_we_o
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH:0] wide_add;
   logic           logical_op;

   assign wide_add   = {1'b0, opa_i} + {1'b0, opb_i};
   assign logical_op = (op_i[3:2] == 2'b11) || (op_i[2:1] == 2'b00);

   always_comb begin
      if (!$isunknown({op_i, opa_i, opb_i, c_flag_i, v_flag_i, shift_c_i, set_flags_i})) begin
         assert_cmp_no_write_R8: assert ((op_i[3:2] == 2'b10) ? !result_we_o : result_we_o);
         assert_cmp_sets_flags_R9: assert ((op_i[3:2] == 2'b10) || (flags_we_o == set_flags_i));
         assert_cmp_flags_R9: assert ((op_i[3:2] != 2'b10) || flags_we_o);
         assert_zero_neg_R6: assert ((z_o == (result_o == '0)) && (n_o == result_o[MSB]));
         assert_logic_cv_R7: assert (!logical_op || ((c_o == shift_c_i) && (v_o == v_flag_i)));
         assert_add_carry_R2: assert (op_i != 4'h4 || ((c_o == wide_add[WIDTH]) && (result_o == wide_add[WIDTH-1:0])));
         assert_sub_noborrow_R3: assert (op_i != 4'h2 || ((c_o == (opb_i <= opa_i)) && (result_o == opa_i - opb_i)));
         assert_rsub_noborrow_R4: assert (op_i != 4'h3 || ((c_o == (opa_i <= opb_i)) && (result_o == opb_i - opa_i)));
      end
   end

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .op_i        (op_i),
   .opa_i       (opa_i),
   .opb_i       (opb_i),
   .c_flag_i    (c_flag_i),
   .v_flag_i    (v_flag_i),
   .shift_c_i   (shift_c_i),
   .set_flags_i (set_flags_i),
   .result_o    (result_o),
   .result_we_o (result_we_o),
   .n_o         (n_o),
   .z_o         (z_o),
   .c_o         (c_o),
   .v_o         (v_o),
   .flags_we_o  (flags_we_o)
);

// File: tb/dp_alu_bench.sv
`timescale 1ns/1ps
module dp_alu_bench;

   logic        clk = 1'b0;
   logic [3:0]  op;
   logic [31:0] a, b;
   logic        cf, vf, sc, sf;
   logic [31:0] res;
   logic        rwe, n, z, c, v, fwe;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dp_alu u_dp_alu (
      .op_i(op), .opa_i(a), .opb_i(b), .c_flag_i(cf), .v_flag_i(vf),
      .shift_c_i(sc), .set_flags_i(sf), .result_o(res), .result_we_o(rwe),
      .n_o(n), .z_o(z), .c_o(c), .v_o(v), .flags_we_o(fwe)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   function automatic string tag_of(input logic [3:0] o);
      case (o)
         4'h4, 4'hB:       return "R2";
         4'h2, 4'hA:       return "R3";
         4'h3:             return "R4";
         4'h5, 4'h6, 4'h7: return "R5";
         default:          return "R1";
      endcase
   endfunction

   function automatic bit out_of_range(input longint x);
      return (x > 64'sd2147483647) || (x < -64'sd2147483648);
   endfunction

   task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h (op=%h a=%h b=%h cin=%b)", t, what, act, exp, op, a, b, cf);
      end
   endtask

   // behavioural reference: 64-bit integers, sign-extended operands
   task automatic apply(input logic [3:0] o, input logic [31:0] ai, input logic [31:0] bi,
                        input logic ci, input logic vi, input logic si, input logic fi);
      longint unsigned ua, ub, s;
      longint sa, sb;
      logic [31:0] er;
      logic ec, ev;
      bit arith;
      @(posedge clk);
      op = o; a = ai; b = bi; cf = ci; vf = vi; sc = si; sf = fi;
      ua = {32'h0, ai}; ub = {32'h0, bi};
      sa = longint'(signed'(ai)); sb = longint'(signed'(bi));
      arith = 1'b1; ec = si; ev = vi; er = '0;
      case (o)
         4'h0, 4'h8: begin er = ai & bi;  arith = 0; end
         4'h1, 4'h9: begin er = ai ^ bi;  arith = 0; end
         4'hC:       begin er = ai | bi;  arith = 0; end
         4'hD:       begin er = bi;       arith = 0; end
         4'hE:       begin er = ai & ~bi; arith = 0; end
         4'hF:       begin er = ~bi;      arith = 0; end
         4'h4, 4'hB: begin s = ua + ub; er = s[31:0]; ec = s > 64'hFFFF_FFFF; ev = out_of_range(sa + sb); end
         4'h2, 4'hA: begin er = ai - bi; ec = (bi <= ai); ev = out_of_range(sa - sb); end
         4'h3:       begin er = bi - ai; ec = (ai <= bi); ev = out_of_range(sb - sa); end
         4'h5: begin s = ua + ub + ci; er = s[31:0]; ec = s > 64'hFFFF_FFFF; ev = out_of_range(sa + sb + ci); end
         4'h6: begin s = ua + {32'h0, ~bi} + ci; er = s[31:0]; ec = s > 64'hFFFF_FFFF; ev = out_of_range(sa - sb - 1 + ci); end
         default: begin s = ub + {32'h0, ~ai} + ci; er = s[31:0]; ec = s > 64'hFFFF_FFFF; ev = out_of_range(sb - sa - 1 + ci); end
      endcase
      @(negedge clk);
      chk(tag_of(o), "result", res, er);
      chk("R6", "N", {31'h0, n}, {31'h0, er[31]});
      chk("R6", "Z", {31'h0, z}, {31'h0, (er == 0)});
      chk(arith ? tag_of(o) : "R7", "C", {31'h0, c}, {31'h0, ec});
      chk(arith ? tag_of(o) : "R7", "V", {31'h0, v}, {31'h0, ev});
      chk("R8", "result_we", {31'h0, rwe}, {31'h0, (o[3:2] != 2'b10)});
      chk("R9", "flags_we", {31'h0, fwe}, {31'h0, (o[3:2] == 2'b10) | fi});
   endtask

   logic [31:0] corner [5] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

   initial begin
      logic [31:0] r0;
      logic c0, v0;
      op = 4'h0; a = '0; b = '0; cf = 0; vf = 0; sc = 0; sf = 0;

      // quiescent state: all-zero inputs give a zero AND result
      apply(4'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R6", "idle Z", {31'h0, z}, 32'h1);

      // corner matrix over every code, carry-in clear and set
      for (int o = 0; o < 16; o++)
         for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
               for (int k = 0; k < 2; k++)
                  apply(4'(o), corner[i], corner[j], k[0], ~k[0], (i + j) % 2 == 1, j[0] ^ k[0]);

      // R10: codes without carry chaining ignore the incoming carry
      foreach (corner[i]) begin
         for (int o = 0; o < 16; o++) begin
            if (o == 5 || o == 6 || o == 7) continue;
            apply(4'(o), corner[i], 32'h1234_5678 ^ corner[i], 1'b0, 1'b1, 1'b0, 1'b1);
            r0 = res; c0 = c; v0 = v;
            apply(4'(o), corner[i], 32'h1234_5678 ^ corner[i], 1'b1, 1'b1, 1'b0, 1'b1);
            chk("R10", "result vs carry-in", res, r0);
            chk("R10", "C vs carry-in", {31'h0, c}, {31'h0, c0});
            chk("R10", "V vs carry-in", {31'h0, v}, {31'h0, v0});
         end
      end

      // random vectors
      for (int t = 0; t < 4000; t++)
         apply(4'($urandom_range(0, 15)), $urandom, $urandom, 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule